// File: doc/BRIEF.md
# Transmit Endpoint FIFO with Short-Packet Control

This block buffers outgoing data for one bulk IN endpoint. Bytes arrive from one of two writers: a CPU byte-write strobe, or a DMA-style port that moves a byte whenever the block raises its request and the port answers with an acknowledge. A single select input decides which writer is live, and the other writer's strobes are dropped. The port sees its request fall while the buffer is full, and it rises again once a closed transaction frees space.

Toward the packet engine the block offers one packet at a time. When at least one maximum-size packet's worth of data is buffered, a full packet is offered without firmware help. A shorter packet, or a zero-length one, is offered only while a short-packet enable flag is set. Firmware can set the flag with a pulse. In auto-short mode the flag is also set when a port burst ends with a remainder that is not a whole number of packets. The engine reads the packet byte by byte with a strobe. It then either closes the transaction, which releases the bytes, or fails it, which rewinds the read position so that the same bytes are offered again.

A small state machine holds the offer. **IDLE** means no packet is offered. **READY** means a packet is offered, its length is latched and no byte of it has been read since it was offered or rewound. **SEND** means at least one byte has been read. The transitions are:
- *offer*: IDLE to READY, when occupancy is at least the maximum packet size, or when the flag is set.
- *first read*: READY to SEND, on a read strobe.
- *close*: READY or SEND to IDLE.
- *fail*: READY or SEND to READY.

Top module: `tx_ep_fifo`

## Requirements
- R1: With `src_sel`=0 only `cpu_wr` writes `cpu_data` and `port_ack` has no effect. With `src_sel`=1 only `port_ack` (while `port_req` is high) writes `port_data` and `cpu_wr` has no effect. A write changes `free_space` at the clock edge where it is taken.
- R2: Bytes appear on `rd_data` in exactly the order in which they were written.
- R3: A write attempt while occupancy is 128 is ignored, and `free_space` stays 0.
- R4: `port_req` is high exactly when `src_sel`=1 and occupancy is below 128. A `port_ack` while `port_req` is low writes nothing.
- R5: `free_space` equals 128 minus occupancy. It changes at the same edge as each accepted write and each release.
- R6: In IDLE, when occupancy is at least `max_pkt` (8 to 64), the next edge enters READY with `pkt_ready`=1 and `pkt_len`=`max_pkt`.
- R7: In IDLE with occupancy below `max_pkt`, a packet is offered only while `short_en`=1. Its length is the occupancy, which may be 0. In IDLE `pkt_ready`=0 and `pkt_len`=0.
- R8: A one-cycle pulse on `fw_short_set` sets `short_en` at the next edge. Closing a packet whose length is below `max_pkt` clears `short_en`. If a set and a clear happen in the same cycle, the set wins.
- R9: With `auto_short`=1 and `src_sel`=1, a `port_end` pulse sets `short_en` only if the occupancy after that edge, taken modulo `max_pkt`, is nonzero.
- R10: While a packet is offered, `rd_data` shows the next unread byte of the packet. Each `rd_strobe` advances to the following byte, but only while fewer than `pkt_len` bytes have been read.
- R11: `txn_fail` in READY or SEND returns to READY with the same length and the read position back at the first byte of the packet.
- R12: `txn_close` in READY or SEND releases `pkt_len` bytes and enters IDLE, so `pkt_ready` is 0 in the following cycle. If `txn_close` and `txn_fail` arrive together, the close takes effect.
- R13: After reset the buffer is empty: `free_space`=128, `pkt_ready`=0, `pkt_len`=0 and `short_en`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| max_pkt | input | 7 | Maximum packet size, 8 to 64 |
| src_sel | input | 1 | Writer select: 0 = CPU, 1 = port |
| cpu_wr | input | 1 | CPU byte-write strobe |
| cpu_data | input | 8 | CPU write byte |
| port_ack | input | 1 | Port transfer acknowledge, one byte per cycle |
| port_data | input | 8 | Port write byte |
| port_end | input | 1 | Pulse marking the end of a port burst |
| port_req | output | 1 | Port request: space is available |
| auto_short | input | 1 | Auto-short mode enable |
| fw_short_set | input | 1 | Firmware pulse that sets the short-packet flag |
| short_en | output | 1 | Short-packet enable flag |
| pkt_ready | output | 1 | A packet is offered |
| pkt_len | output | 7 | Length of the offered packet |
| rd_strobe | input | 1 | Packet engine byte read strobe |
| rd_data | output | 8 | Next unread byte of the offered packet |
| txn_close | input | 1 | Transaction closed: release the packet |
| txn_fail | input | 1 | Transaction failed: rewind the packet |
| free_space | output | 8 | Free bytes in the buffer, 0 to 128 |

## Verification
The bench fills the buffer to exactly 128 bytes through the port and then keeps pressing both writers. A design with an off-by-one full test would either drop the last byte or overwrite the oldest unsent byte, which shows up as a wrong `free_space` or a corrupted `rd_data`. Short packets are exercised through firmware, including a zero-length packet from an empty buffer. They are also exercised through auto-short, with port bursts that leave a remainder and with bursts that end on a packet boundary. A design that skipped the modulo test would raise `short_en` on the boundary case and so emit a zero-length packet. A design that kept the flag after the close would send the next remainder without being asked. A mid-packet failure must replay from the first byte, and the bench's reference queue catches a design that resumed where it stopped or that released the bytes.

// File: rtl/tx_ep_pkg.sv
package tx_ep_pkg;
    localparam int unsigned DEPTH = 128;
    localparam int unsigned DW    = 8;
    localparam int unsigned PW    = 7;
    localparam int unsigned AW    = $clog2(DEPTH);
    localparam int unsigned CW    = AW + 1;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READY = 2'd1,
        ST_SEND  = 2'd2
    } tx_state_t;
endpackage

// File: rtl/tx_ep_wrsel.sv
module tx_ep_wrsel
    import tx_ep_pkg::*;
#(
    parameter int unsigned D_W   = DW,
    parameter int unsigned C_W   = CW,
    parameter int unsigned DEP   = DEPTH
) (
    input  logic           src_sel,
    input  logic           cpu_wr,
    input  logic [D_W-1:0] cpu_data,
    input  logic           port_ack,
    input  logic [D_W-1:0] port_data,
    input  logic [C_W-1:0] count,
    output logic           wr_en,
    output logic [D_W-1:0] wr_data,
    output logic           port_req
);
    logic room;

    always_comb begin
        room     = (count < C_W'(DEP));
        port_req = src_sel && room;
        if (src_sel) begin
            wr_en   = port_ack && room;
            wr_data = port_data;
        end else begin
            wr_en   = cpu_wr && room;
            wr_data = cpu_data;
        end
    end
endmodule

// File: rtl/tx_ep_store.sv
module tx_ep_store
    import tx_ep_pkg::*;
#(
    parameter int unsigned D_W = DW,
    parameter int unsigned A_W = AW,
    parameter int unsigned DEP = DEPTH
) (
    input  logic           clk,
    input  logic           wr_en,
    input  logic [A_W-1:0] wr_addr,
    input  logic [D_W-1:0] wr_data,
    input  logic [A_W-1:0] rd_addr,
    output logic [D_W-1:0] rd_data
);
    logic [D_W-1:0] mem [DEP];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/tx_ep_txctl.sv
module tx_ep_txctl
    import tx_ep_pkg::*;
#(
    parameter int unsigned P_W = PW,
    parameter int unsigned A_W = AW,
    parameter int unsigned C_W = CW,
    parameter int unsigned DEP = DEPTH
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [P_W-1:0] max_pkt,
    input  logic           wr_en,
    input  logic           src_sel,
    input  logic           port_end,
    input  logic           auto_short,
    input  logic           fw_short_set,
    input  logic           rd_strobe,
    input  logic           txn_close,
    input  logic           txn_fail,
    output logic [C_W-1:0] count,
    output logic [A_W-1:0] wr_addr,
    output logic [A_W-1:0] rd_addr,
    output logic           pkt_ready,
    output logic [P_W-1:0] pkt_len,
    output logic           short_en,
    output logic [C_W-1:0] free_space
);
    tx_state_t      state_q, state_d;
    logic [P_W-1:0] len_q, len_d;
    logic [P_W-1:0] sent_q, sent_d;
    logic [A_W-1:0] head_q, wptr_q;
    logic [C_W-1:0] cnt_q, cnt_next, maxc, resid, rel;
    logic           short_q, short_next;
    logic           busy, close_ok, fail_ok, rd_ok, full_avail, start, auto_hit;

    // qualify engine events
    always_comb begin
        maxc       = C_W'(max_pkt);
        busy       = (state_q != ST_IDLE);
        close_ok   = txn_close && busy;
        fail_ok    = txn_fail && busy && !txn_close;
        rd_ok      = rd_strobe && busy && !close_ok && !fail_ok && (sent_q < len_q);
        full_avail = (cnt_q >= maxc);
        start      = (state_q == ST_IDLE) && (full_avail || short_q);
        rel        = close_ok ? C_W'(len_q) : '0;
        cnt_next   = cnt_q + C_W'(wr_en) - rel;
        resid      = (maxc != '0) ? (cnt_next % maxc) : '0;
        auto_hit   = src_sel && auto_short && port_end && (resid != '0);
        short_next = (short_q && !(close_ok && (len_q < max_pkt)))
                     || auto_hit || fw_short_set;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        len_d   = len_q;
        sent_d  = sent_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = ST_READY;
                    len_d   = full_avail ? max_pkt : P_W'(cnt_q);
                    sent_d  = '0;
                end
            end
            ST_READY: begin
                if (close_ok) begin
                    state_d = ST_IDLE;
                    sent_d  = '0;
                end else if (fail_ok) begin
                    state_d = ST_READY;
                    sent_d  = '0;
                end else if (rd_ok) begin
                    state_d = ST_SEND;
                    sent_d  = sent_q + 1'b1;
                end
            end
            ST_SEND: begin
                if (close_ok) begin
                    state_d = ST_IDLE;
                    sent_d  = '0;
                end else if (fail_ok) begin
                    state_d = ST_READY;
                    sent_d  = '0;
                end else if (rd_ok) begin
                    sent_d  = sent_q + 1'b1;
                end
            end
            default: begin
                state_d = ST_IDLE;
                sent_d  = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            len_q   <= '0;
            sent_q  <= '0;
        end else begin
            state_q <= state_d;
            len_q   <= len_d;
            sent_q  <= sent_d;
        end
    end

    // pointers, occupancy and flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head_q  <= '0;
            wptr_q  <= '0;
            cnt_q   <= '0;
            short_q <= 1'b0;
        end else begin
            cnt_q   <= cnt_next;
            short_q <= short_next;
            if (wr_en)    wptr_q <= wptr_q + 1'b1;
            if (close_ok) head_q <= head_q + A_W'(len_q);
        end
    end

    // outputs
    always_comb begin
        pkt_ready  = (state_q != ST_IDLE);
        pkt_len    = pkt_ready ? len_q : '0;
        short_en   = short_q;
        count      = cnt_q;
        free_space = C_W'(DEP) - cnt_q;
        wr_addr    = wptr_q;
        rd_addr    = head_q + A_W'(sent_q);
    end

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= C_W'(DEP));

    a_r3_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == C_W'(DEP) && !close_ok) |=> (cnt_q == C_W'(DEP)));

    a_r6_full_offer: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && cnt_q >= maxc) |=> (pkt_ready && pkt_len == $past(max_pkt)));

    a_r7_short_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_ready && pkt_len < max_pkt) |-> short_q);

    a_r8_clear_on_close: assert property (@(posedge clk) disable iff (!rst_n)
        (close_ok && len_q < max_pkt && !fw_short_set && !auto_hit) |=> !short_q);

    a_r9_no_zero_auto: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(short_q) && !$past(fw_short_set)) |-> (cnt_q % maxc != '0));

    a_r12_release: assert property (@(posedge clk) disable iff (!rst_n)
        (close_ok && !wr_en) |=> (cnt_q == $past(cnt_q) - $past(C_W'(len_q))));
endmodule

// File: rtl/tx_ep_fifo.sv
module tx_ep_fifo
    import tx_ep_pkg::*;
#(
    parameter int unsigned D_W = DW,
    parameter int unsigned P_W = PW,
    parameter int unsigned DEP = DEPTH,
    localparam int unsigned A_W = $clog2(DEP),
    localparam int unsigned C_W = A_W + 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [P_W-1:0] max_pkt,
    input  logic           src_sel,
    input  logic           cpu_wr,
    input  logic [D_W-1:0] cpu_data,
    input  logic           port_ack,
    input  logic [D_W-1:0] port_data,
    input  logic           port_end,
    output logic           port_req,
    input  logic           auto_short,
    input  logic           fw_short_set,
    output logic           short_en,
    output logic           pkt_ready,
    output logic [P_W-1:0] pkt_len,
    input  logic           rd_strobe,
    output logic [D_W-1:0] rd_data,
    input  logic           txn_close,
    input  logic           txn_fail,
    output logic [C_W-1:0] free_space
);
    logic           wr_en;
    logic [D_W-1:0] wr_data;
    logic [C_W-1:0] count;
    logic [A_W-1:0] wr_addr, rd_addr;

    tx_ep_wrsel #(.D_W(D_W), .C_W(C_W), .DEP(DEP)) u_wrsel (
        .src_sel   (src_sel),
        .cpu_wr    (cpu_wr),
        .cpu_data  (cpu_data),
        .port_ack  (port_ack),
        .port_data (port_data),
        .count     (count),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .port_req  (port_req)
    );

    tx_ep_store #(.D_W(D_W), .A_W(A_W), .DEP(DEP)) u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    tx_ep_txctl #(.P_W(P_W), .A_W(A_W), .C_W(C_W), .DEP(DEP)) u_ctl (
        .clk          (clk),
        .rst_n        (rst_n),
        .max_pkt      (max_pkt),
        .wr_en        (wr_en),
        .src_sel      (src_sel),
        .port_end     (port_end),
        .auto_short   (auto_short),
        .fw_short_set (fw_short_set),
        .rd_strobe    (rd_strobe),
        .txn_close    (txn_close),
        .txn_fail     (txn_fail),
        .count        (count),
        .wr_addr      (wr_addr),
        .rd_addr      (rd_addr),
        .pkt_ready    (pkt_ready),
        .pkt_len      (pkt_len),
        .short_en     (short_en),
        .free_space   (free_space)
    );

    a_r4_port_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel && free_space == '0) |-> !port_req);
endmodule

// File: tb/tx_ep_fifo_test.sv
module tx_ep_fifo_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] max_pkt = 7'd16;
    logic       src_sel = 1'b0, cpu_wr = 1'b0, port_ack = 1'b0, port_end = 1'b0;
    logic [7:0] cpu_data = '0, port_data = '0;
    logic       auto_short = 1'b0, fw_short_set = 1'b0;
    logic       rd_strobe = 1'b0, txn_close = 1'b0, txn_fail = 1'b0;
    logic       port_req, short_en, pkt_ready;
    logic [6:0] pkt_len;
    logic [7:0] rd_data, free_space;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    tx_ep_fifo uut (
        .clk(clk), .rst_n(rst_n), .max_pkt(max_pkt), .src_sel(src_sel),
        .cpu_wr(cpu_wr), .cpu_data(cpu_data), .port_ack(port_ack),
        .port_data(port_data), .port_end(port_end), .port_req(port_req),
        .auto_short(auto_short), .fw_short_set(fw_short_set),
        .short_en(short_en), .pkt_ready(pkt_ready), .pkt_len(pkt_len),
        .rd_strobe(rd_strobe), .rd_data(rd_data), .txn_close(txn_close),
        .txn_fail(txn_fail), .free_space(free_space)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // behavioural reference model
    logic [7:0] mq[$];
    int  ms = 0, mlen = 0, mrd = 0;
    bit  msh = 0;

    always @(posedge clk) begin
        int sz, nc;
        bit w, cl, fl, st, shn;
        logic [7:0] d;
        if (!rst_n) begin
            mq.delete(); ms = 0; mlen = 0; mrd = 0; msh = 0;
        end else begin
            sz = mq.size(); w = 0; d = '0;
            if (!src_sel && cpu_wr && sz < 128) begin w = 1; d = cpu_data; end
            if (src_sel && port_ack && sz < 128) begin w = 1; d = port_data; end
            cl = txn_close && ms != 0;
            fl = txn_fail && ms != 0 && !cl;
            st = rd_strobe && ms != 0 && !cl && !fl && mrd < mlen;
            nc = sz + int'(w) - (cl ? mlen : 0);
            shn = msh;
            if (cl && mlen < int'(max_pkt)) shn = 0;
            if (src_sel && auto_short && port_end && (nc % int'(max_pkt)) != 0) shn = 1;
            if (fw_short_set) shn = 1;
            if (ms == 0) begin
                if (sz >= int'(max_pkt)) begin ms = 1; mlen = int'(max_pkt); mrd = 0; end
                else if (msh) begin ms = 1; mlen = sz; mrd = 0; end
            end else if (cl) begin
                ms = 0; mrd = 0;
            end else if (fl) begin
                ms = 1; mrd = 0;
            end else if (st) begin
                ms = 2; mrd = mrd + 1;
            end
            if (cl) repeat (mlen) void'(mq.pop_front());
            if (w) mq.push_back(d);
            msh = shn;
        end
        #1;
        if (rst_n) begin
            check(free_space == 8'(128 - mq.size()), "R5", "free_space",
                  int'(free_space), 128 - mq.size());
            check(port_req == (src_sel && mq.size() < 128), "R4", "port_req",
                  int'(port_req), int'(src_sel && mq.size() < 128));
            check(pkt_ready == (ms != 0), "R6", "pkt_ready", int'(pkt_ready), int'(ms != 0));
            check(int'(pkt_len) == ((ms != 0) ? mlen : 0), "R7", "pkt_len",
                  int'(pkt_len), (ms != 0) ? mlen : 0);
            check(short_en == msh, "R8", "short_en", int'(short_en), int'(msh));
            if (ms != 0 && mrd < mlen && mrd < mq.size())
                check(rd_data == mq[mrd], "R10", "rd_data", int'(rd_data), int'(mq[mrd]));
        end
    end

    task automatic cpu_write(input int n, input int base);
        src_sel = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk); cpu_wr = 1'b1; cpu_data = 8'(base + i);
        end
        @(negedge clk); cpu_wr = 1'b0;
    endtask

    task automatic port_burst(input int n, input int base);
        int i;
        src_sel = 1'b1; i = 0;
        while (i < n) begin
            @(negedge clk);
            cpu_wr = 1'b1; cpu_data = 8'hEE;   // R1: CPU strobe ignored while port selected
            if (port_req) begin
                port_ack = 1'b1; port_data = 8'(base + i); i++;
            end else port_ack = 1'b0;
        end
        @(negedge clk); port_ack = 1'b0; cpu_wr = 1'b0; port_end = 1'b1;
        @(negedge clk); port_end = 1'b0;
    endtask

    task automatic read_bytes(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); rd_strobe = 1'b1;
        end
        @(negedge clk); rd_strobe = 1'b0;
    endtask

    task automatic serve(input int fail_at, input int first_exp, input int len_exp);
        int len;
        do @(negedge clk); while (!pkt_ready);
        len = int'(pkt_len);
        check(len == len_exp, "R6", "offered length", len, len_exp);
        if (len > 0)
            check(int'(rd_data) == first_exp, "R2", "first byte", int'(rd_data), first_exp);
        if (fail_at >= 0) begin
            read_bytes(fail_at);
            txn_fail = 1'b1;
            @(negedge clk); txn_fail = 1'b0;
            check(pkt_ready && int'(pkt_len) == len, "R11", "replay length", int'(pkt_len), len);
            if (len > 0)
                check(int'(rd_data) == first_exp, "R11", "replay first byte",
                      int'(rd_data), first_exp);
        end
        read_bytes(len);
        txn_close = 1'b1;
        @(negedge clk); txn_close = 1'b0;
        check(!pkt_ready, "R12", "pkt_ready after close", int'(pkt_ready), 0);
    endtask

    task automatic pulse_fw;
        @(negedge clk); fw_short_set = 1'b1;
        @(negedge clk); fw_short_set = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(free_space == 8'd128, "R13", "free after reset", int'(free_space), 128);
        check(!pkt_ready && pkt_len == 0, "R13", "no packet after reset", int'(pkt_ready), 0);
        check(!short_en, "R13", "flag after reset", int'(short_en), 0);

        // R1: port acknowledge ignored while CPU selected
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); port_ack = 1'b1; port_data = 8'h55;
        end
        @(negedge clk); port_ack = 1'b0;
        check(free_space == 8'd128, "R1", "port ignored when cpu selected", int'(free_space), 128);

        cpu_write(20, 8'h10);
        check(free_space == 8'd108, "R1", "cpu writes taken", int'(free_space), 108);
        serve(-1, 8'h10, 16);
        repeat (3) @(negedge clk);
        check(!pkt_ready, "R7", "remainder held without flag", int'(pkt_ready), 0);

        pulse_fw;
        serve(2, 8'h20, 4);
        @(negedge clk);
        check(!short_en, "R8", "flag cleared by short close", int'(short_en), 1'b0);

        pulse_fw;              // zero-length packet from an empty buffer
        serve(-1, 0, 0);

        // fill to full through the port
        port_burst(128, 8'h40);
        src_sel = 1'b1;
        for (int i = 0; i < 2; i++) begin
            @(negedge clk); port_ack = 1'b1; port_data = 8'hAA;
        end
        @(negedge clk); port_ack = 1'b0;
        check(free_space == 8'd0, "R4", "ack while stalled ignored", int'(free_space), 0);
        cpu_write(2, 8'hBB);
        check(free_space == 8'd0, "R3", "cpu write to full ignored", int'(free_space), 0);
        for (int p = 0; p < 8; p++) serve(-1, (8'h40 + 16 * p) & 8'hFF, 16);

        // auto-short with a remainder
        auto_short = 1'b1;
        port_burst(37, 8'h80);
        @(negedge clk);
        check(short_en, "R9", "auto flag on remainder", int'(short_en), 1);
        serve(-1, 8'h80, 16);
        serve(3, 8'h90, 16);
        serve(-1, 8'hA0, 5);

        // auto-short on a packet boundary
        port_burst(32, 8'hC0);
        @(negedge clk);
        check(!short_en, "R9", "no auto flag on boundary", int'(short_en), 0);
        serve(-1, 8'hC0, 16);
        serve(-1, 8'hD0, 16);
        auto_short = 1'b0;

        // largest packet size
        max_pkt = 7'd64;
        cpu_write(70, 8'h00);
        serve(-1, 8'h00, 64);
        pulse_fw;
        serve(-1, 8'h40, 6);
        repeat (3) @(negedge clk);
        check(free_space == 8'd128, "R12", "all released", int'(free_space), 128);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: all requirements actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule